// File: doc/BRIEF.md
# Dual-mode quad storage latch

This block stores a small vector of bits, four by default. Each bit takes two inputs of its own: a data input and an active-low set input. A single shared active-low enable and a single shared active-low clear act on every bit. When the enable is asserted and a bit's set input is low, the bit follows its data input in the manner of a transparent D latch. When the set input is high, the same two inputs act as a set/reset pair. A low data input resets the bit, and a high data input together with a high set input leaves the bit unchanged.

The behaviour is written as a clock-synchronous equivalent of a latch. Every input is sampled on the rising edge of the system clock, and the stored state changes on that edge. The outputs show the new state from the following cycle on. The clear has priority over everything else, and a deasserted enable freezes every bit.

Top module: `dual_mode_latch`

## Requirements
- R1: When `clr_n` is 0 at a rising clock edge, every bit of `q` is 0 after that edge, whatever the values of `en_n`, `d` and `s_n`.
- R2: When `clr_n` is 1 and `en_n` is 1 at an edge, `q` keeps its previous value, and `d` and `s_n` have no effect.
- R3: When `clr_n` is 1, `en_n` is 0 and `s_n[i]` is 0, `q[i]` takes the value of `d[i]` after the edge (follow mode).
- R4: When `clr_n` is 1, `en_n` is 0, `s_n[i]` is 1 and `d[i]` is 0, `q[i]` becomes 0 after the edge.
- R5: When `clr_n` is 1, `en_n` is 0, `s_n[i]` is 1 and `d[i]` is 1, `q[i]` keeps its previous value.
- R6: Within a bit, a low `d[i]` always gives a 0 result when enabled, including when `s_n[i]` is also low.
- R7: Each bit is updated independently from its own `d[i]` and `s_n[i]`. No bit's next value depends on another bit's inputs.
- R8: During and directly after reset, `q` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| clr_n | input | 1 | Master clear, active low, synchronous |
| en_n | input | 1 | Shared enable, active low |
| d | input | W | Per-bit data input |
| s_n | input | W | Per-bit set input, active low |
| q | output | W | Stored state |

## Verification
The assertions check on every cycle that a clear zeroes the state and that a disabled cycle leaves the state stable. They also check, bit by bit, that an enabled cycle with a low data input clears the bit, that follow mode copies the data input, and that the hold combination keeps the bit. Whether each bit really acts alone cannot be shown by any single cycle's property. The bench's mixed per-bit patterns show it, along with the way the modes interleave over long random runs: a hold after a follow, a freeze after a set.

// File: rtl/dual_mode_latch.sv
module dual_mode_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         en_n,
  input  logic [W-1:0] d,
  input  logic [W-1:0] s_n,
  output logic [W-1:0] q
);

  logic [W-1:0] state;
  logic [W-1:0] next_bit;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign next_bit[i] = d[i] & (~s_n[i] | state[i]);
  end

  always_ff @(posedge clk) begin
    if (!clr_n)
      state <= '0;
    else if (!en_n)
      state <= next_bit;
  end

  assign q = state;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    disable iff (!past_ok) !clr_n |=> (q == '0)); // R1

  AST_DISABLED_HOLD: assert property (@(posedge clk)
    disable iff (!past_ok || !clr_n) en_n |=> $stable(q)); // R2

  for (genvar k = 0; k < W; k++) begin : g_chk
    AST_FOLLOW: assert property (@(posedge clk)
      disable iff (!past_ok || !clr_n)
      (!en_n && !s_n[k]) |=> (q[k] == $past(d[k]))); // R3

    AST_D_LOW_CLEARS: assert property (@(posedge clk)
      disable iff (!past_ok || !clr_n)
      (!en_n && !d[k]) |=> !q[k]); // R4 R6

    AST_SR_HOLD: assert property (@(posedge clk)
      disable iff (!past_ok || !clr_n)
      (!en_n && s_n[k] && d[k]) |=> $stable(q[k])); // R5
  end

endmodule

// File: tb/test_dual_mode_latch.sv
module test_dual_mode_latch;
  localparam int W = 4;

  logic clk = 0;
  logic clr_n, en_n;
  logic [W-1:0] d, s_n, q;
  logic [W-1:0] model;
  int vectors = 0, errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dual_mode_latch #(.W(W)) i_dual_mode_latch (
    .clk(clk), .clr_n(clr_n), .en_n(en_n), .d(d), .s_n(s_n), .q(q)
  );

  function automatic logic [W-1:0] ref_next(logic [W-1:0] cur, logic c, logic e,
                                             logic [W-1:0] dd, logic [W-1:0] ss);
    logic [W-1:0] r = cur;
    if (!c) return '0;
    if (e) return cur;
    for (int i = 0; i < W; i++) begin
      if (dd[i] == 1'b0) r[i] = 1'b0;
      else if (ss[i] == 1'b0) r[i] = 1'b1;
      else r[i] = cur[i];
    end
    return r;
  endfunction

  task automatic step(input logic c, input logic e, input logic [W-1:0] dd,
                      input logic [W-1:0] ss, input string tag);
    clr_n = c; en_n = e; d = dd; s_n = ss;
    @(posedge clk);
    model = ref_next(model, c, e, dd, ss);
    @(negedge clk);
    vectors++;
    if (q !== model) begin
      errors++;
      $display("FAIL %s: q=%b expected %b", tag, q, model);
    end
  endtask

  initial begin
    model = '0;
    clr_n = 0; en_n = 1; d = '0; s_n = '1;
    @(posedge clk); @(negedge clk);
    vectors++;
    if (q !== '0) begin errors++; $display("FAIL R8: q=%b expected 0000", q); end
    step(0, 0, 4'hF, 4'h0, "R8");
    step(1, 0, 4'b1010, 4'b0000, "R3");
    step(1, 0, 4'b0101, 4'b0000, "R3");
    step(1, 1, 4'b0000, 4'b0000, "R2");
    step(1, 1, 4'b1111, 4'b1111, "R2");
    step(1, 0, 4'b1111, 4'b1111, "R5");
    step(1, 0, 4'b1110, 4'b1111, "R4");
    step(1, 0, 4'b0000, 4'b0000, "R6");
    step(1, 0, 4'b1111, 4'b0101, "R7");
    step(1, 0, 4'b1101, 4'b1001, "R7");
    step(1, 0, 4'b1111, 4'b0000, "R3");
    step(0, 0, 4'b1111, 4'b0000, "R1");
    step(1, 0, 4'b1111, 4'b0000, "R3");
    step(0, 1, 4'b1111, 4'b1111, "R1");
    for (int n = 0; n < 2000; n++) begin
      logic c;
      c = ($urandom_range(0, 15) != 0);
      step(c, $urandom_range(0, 3) == 0, W'($urandom), W'($urandom), "R7");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule